// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit applies one of eight shift or rotate operations to an 8-bit or 16-bit operand. It moves the operand by one bit position per clock cycle. The number of positions comes from an 8-bit count, which can hold an immediate value or the contents of a count register. The caller presents the operand, the width select, the operation code, the count and the incoming carry flag, then pulses `start`. The unit returns the transformed value and the new carry flag, and raises `done` for one cycle when the work is finished.

The unit handles the carry flag differently for each family of operation:

- **Plain rotates** copy the departing bit into the carry flag and also into the vacated end of the operand.
- **Rotates through carry** put the departing bit into the carry flag and move the old carry flag into the vacated end.
- **Left shifts** fill the vacated bit 0 with zero.
- **Logical right shifts** fill the top position with zero.
- **Arithmetic right shifts** fill the top position with a copy of the sign bit.

The top bit position follows the selected width.

Top module: `shift_rot_unit`

## Requirements
- R1: Opcode 000 rotates left and opcode 001 rotates right. In both, the bit that leaves goes into `carryOut` and into the vacated end. With operand 1Ch, one step left gives 38h and one step right gives 0Eh, each with carry 0.
- R2: Opcode 010 rotates left through carry: the top bit goes to carry and the old carry enters bit 0. Opcode 011 rotates right through carry: bit 0 goes to carry and the old carry enters the top bit. With carry 1 and operand 1Ch, one step gives 39h (left) or 8Eh (right), each with carry 0.
- R3: Opcodes 100 and 110 shift left: the top bit goes to carry and 0 enters bit 0. Operand E0h gives C0h with carry 1.
- R4: Opcode 101 shifts right and inserts 0 at the top. Opcode 111 shifts right and keeps the sign bit at the top. With opcode 111, E0h gives F0h and 4Ch gives 26h, each with carry 0. In every right shift, bit 0 goes to carry.
- R5: A count N of 1 or more gives the same result as N single steps. `done` rises N cycles after the clock edge that accepts `start`.
- R6: A count of 0 raises `done` right after the accepting edge. The operand and carry come back unchanged.
- R7: With `wide`=0, only bits 7:0 take part, bit 7 is the top bit, and `result[15:8]` reads 0. With `wide`=1, bit 15 is the top bit.
- R8: `done` is high for exactly one cycle per accepted start.
- R9: A `start` that arrives while an operation is in progress has no effect on that operation.
- R10: `result` and `carryOut` hold their values from completion until the next accepted start.
- R11: After reset, `result`=0, `carryOut`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when idle |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| opSel | input | 3 | Operation code, see R1 to R4 |
| count | input | 8 | Number of bit positions |
| operand | input | 16 | Value to transform |
| carryIn | input | 1 | Incoming carry flag |
| result | output | 16 | Transformed value |
| carryOut | output | 1 | Resulting carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle:

- **A new request during a run.** The bench raises `start` again in the middle of a long run with a different operand, count and opcode. It judges the outcome by requiring the first request's result and timing.
- **Completion and acceptance together.** A count-0 request completes in the very cycle it is accepted. The bench issues back-to-back count-0 and count-1 requests. It checks `done` timing against the count and checks that each result matches its own request.

A sweep over every opcode, both widths, several operands, both carry values and counts crossing the width boundaries compares each outcome with an arithmetic model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } shOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } shCtl_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output shCtl_t           ctl,
  output logic             busy,
  output logic             done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic             lastStep;

  assign accept   = (state == ST_IDLE) && start;
  assign lastStep = (state == ST_RUN) && (remain == CNT_W'(1));
  assign busy     = (state == ST_RUN);

  always_comb begin
    ctl      = '0;
    ctl.load = accept;
    ctl.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (count == '0) begin
              done <= 1'b1;
            end else begin
              remain <= count;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          remain <= remain - CNT_W'(1);
          if (lastStep) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shrot_dpath.sv
module shrot_dpath
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shCtl_t            ctl,
  input  logic              wide,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] valQ, valNext;
  logic              cfQ, cfNext;
  shOp_t             opQ;
  logic              wideQ;
  logic              topBit, inBit, outBit;

  assign topBit = wideQ ? valQ[DATA_W-1] : valQ[NARROW_W-1];

  always_comb begin
    inBit   = 1'b0;
    outBit  = 1'b0;
    valNext = valQ;
    if (!opQ[0]) begin
      // left-moving family
      outBit = topBit;
      case (opQ)
        OP_ROL:  inBit = topBit;
        OP_RCL:  inBit = cfQ;
        default: inBit = 1'b0;
      endcase
      valNext = {valQ[DATA_W-2:0], inBit};
      if (!wideQ) valNext = valNext & NARROW_MASK;
    end else begin
      // right-moving family
      outBit = valQ[0];
      case (opQ)
        OP_ROR:  inBit = valQ[0];
        OP_RCR:  inBit = cfQ;
        OP_SAR:  inBit = topBit;
        default: inBit = 1'b0;
      endcase
      valNext = valQ >> 1;
      if (wideQ) valNext[DATA_W-1]   = inBit;
      else       valNext[NARROW_W-1] = inBit;
    end
    cfNext = outBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ  <= '0;
      cfQ   <= 1'b0;
      opQ   <= OP_ROL;
      wideQ <= 1'b0;
    end else if (ctl.load) begin
      valQ  <= wide ? operand : (operand & NARROW_MASK);
      cfQ   <= carryIn;
      opQ   <= shOp_t'(opSel);
      wideQ <= wide;
    end else if (ctl.step) begin
      valQ <= valNext;
      cfQ  <= cfNext;
    end
  end

  assign result   = valQ;
  assign carryOut = cfQ;

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wide,
  input  logic [2:0]        opSel,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              done
);

  shCtl_t ctl;
  logic   busy;

  shrot_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .count (count),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  shrot_dpath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wide     (wide),
    .opSel    (opSel),
    .operand  (operand),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              wide,
  input logic [CNT_W-1:0]  count,
  input logic              carryIn,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              done
);

  logic lastWide;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lastWide <= 1'b0;
    else if (start && !busy)  lastWide <= wide;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done);

  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && count == '0 |=> done && !busy && carryOut == $past(carryIn));

  // R5
  run_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && count != '0 |=> busy && !done);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(result) && $stable(carryOut));

  // R7
  narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !lastWide |-> result[DATA_W-1:NARROW_W] == '0);

endmodule

bind shift_rot_unit shrot_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .wide     (wide),
  .count    (count),
  .carryIn  (carryIn),
  .result   (result),
  .carryOut (carryOut),
  .done     (done)
);

// File: tb/shift_rot_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rot_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [7:0]  count = 8'd0;
  logic [15:0] operand = 16'h0;
  logic        carryIn = 1'b0;
  logic [15:0] result;
  logic        carryOut;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shift_rot_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .wide(wide), .opSel(opSel),
    .count(count), .operand(operand), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .done(done)
  );

  function automatic logic [16:0] refModel(input logic [2:0] op, input logic w,
                                           input logic [15:0] v, input logic c, input int n);
    logic [15:0] x;
    logic cf, o, ins;
    int top;
    x   = w ? v : {8'h00, v[7:0]};
    cf  = c;
    top = w ? 15 : 7;
    for (int k = 0; k < n; k++) begin
      if (op[0] == 1'b0) begin
        o = x[top];
        ins = (op == 3'd0) ? o : (op == 3'd2) ? cf : 1'b0;
        x = {x[14:0], ins};
        if (!w) x[15:8] = 8'h00;
      end else begin
        o = x[0];
        ins = (op == 3'd1) ? o : (op == 3'd3) ? cf : (op == 3'd7) ? x[top] : 1'b0;
        x = x >> 1;
        x[top] = ins;
      end
      cf = o;
    end
    return {cf, x};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request and check timing, value and pulse width
  task automatic runOne(input string req, input logic [2:0] op, input logic w,
                        input logic [15:0] v, input logic c, input int n);
    logic [16:0] exp;
    int cyc;
    exp = refModel(op, w, v, c, n);
    @(negedge clk);
    opSel = op; wide = w; operand = v; carryIn = c; count = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check({req, " R5 latency"}, 32'(cyc), 32'(n));
    check({req, " value"}, {15'h0, carryOut, result}, {15'h0, exp});
    @(negedge clk);
    check({req, " R8 pulse"}, {31'h0, done}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] vals[4];
    int cnts[8];
    logic [16:0] exp;
    vals = '{16'h001C, 16'h00E0, 16'h804C, 16'hB3A5};
    cnts = '{0, 1, 2, 7, 8, 9, 16, 17};

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {14'h0, done, carryOut, result}, 32'h0);
    rstN = 1'b1;

    // Single-step cases with known values
    runOne("R1 rol", 3'd0, 1'b0, 16'h1C, 1'b0, 1);
    check("R1 rol 38h", {31'h0, result == 16'h38 && !carryOut}, 32'h1);
    runOne("R1 ror", 3'd1, 1'b0, 16'h1C, 1'b0, 1);
    check("R1 ror 0Eh", {31'h0, result == 16'h0E && !carryOut}, 32'h1);
    runOne("R2 rcl", 3'd2, 1'b0, 16'h1C, 1'b1, 1);
    check("R2 rcl 39h", {31'h0, result == 16'h39 && !carryOut}, 32'h1);
    runOne("R2 rcr", 3'd3, 1'b0, 16'h1C, 1'b1, 1);
    check("R2 rcr 8Eh", {31'h0, result == 16'h8E && !carryOut}, 32'h1);
    runOne("R3 shl", 3'd4, 1'b0, 16'hE0, 1'b0, 1);
    check("R3 shl C0h", {31'h0, result == 16'hC0 && carryOut}, 32'h1);
    runOne("R3 sal", 3'd6, 1'b0, 16'hE0, 1'b0, 1);
    check("R3 sal C0h", {31'h0, result == 16'hC0 && carryOut}, 32'h1);
    runOne("R4 sar", 3'd7, 1'b0, 16'hE0, 1'b0, 1);
    check("R4 sar F0h", {31'h0, result == 16'hF0 && !carryOut}, 32'h1);
    runOne("R4 sar", 3'd7, 1'b0, 16'h4C, 1'b0, 1);
    check("R4 sar 26h", {31'h0, result == 16'h26 && !carryOut}, 32'h1);
    runOne("R4 shr", 3'd5, 1'b1, 16'h8001, 1'b0, 1);
    check("R4 shr 4000h", {31'h0, result == 16'h4000 && carryOut}, 32'h1);

    // R6 zero count leaves operand and carry
    runOne("R6 zero", 3'd2, 1'b1, 16'hA5C3, 1'b1, 0);
    check("R6 unchanged", {15'h0, carryOut, result}, {15'h0, 1'b1, 16'hA5C3});
    // R7 narrow drops upper byte
    runOne("R7 narrow", 3'd0, 1'b0, 16'hFF81, 1'b0, 3);
    check("R7 upper zero", {24'h0, result[15:8]}, 32'h0);

    // Sweep: R1 R2 R3 R4 R5 R7
    for (int op = 0; op < 8; op++)
      for (int w = 0; w < 2; w++)
        for (int vi = 0; vi < 4; vi++)
          for (int c = 0; c < 2; c++)
            for (int ci = 0; ci < 8; ci++)
              runOne("R5 sweep", 3'(op), 1'(w), vals[vi], 1'(c), cnts[ci]);

    // R9 start during a run is ignored
    exp = refModel(3'd3, 1'b1, 16'h1234, 1'b1, 10);
    @(negedge clk);
    opSel = 3'd3; wide = 1'b1; operand = 16'h1234; carryIn = 1'b1; count = 8'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    opSel = 3'd5; operand = 16'hFFFF; count = 8'd0; carryIn = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int cyc = 4;
      while (!done && cyc < 300) begin @(negedge clk); cyc++; end
      check("R9 latency", 32'(cyc), 32'd10);
    end
    check("R9 value", {15'h0, carryOut, result}, {15'h0, exp});

    // R10 hold with changing inputs and no start
    operand = 16'h5555; carryIn = ~exp[16]; opSel = 3'd0; count = 8'd4;
    repeat (6) @(negedge clk);
    check("R10 hold", {15'h0, carryOut, result}, {15'h0, exp});

    // Back-to-back count 0 then count 1 (completion and acceptance adjacent)
    runOne("R6 b2b", 3'd1, 1'b0, 16'h0081, 1'b0, 0);
    runOne("R6 b2b", 3'd1, 1'b0, 16'h0081, 1'b0, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule